// File: doc/BRIEF.md
# Register History Buffer with Rollback

This block keeps a precise register state for a pipeline whose results land in the working register file as soon as they are produced. When an instruction issues, the block reads the value that its destination register holds at that moment, then files that value in a fresh tail entry together with the register number and the instruction's PC. The entry index goes back to the pipeline as a tag.

A finishing instruction presents its tag, destination, result and exception flag. The result goes straight to the register file write port in the same cycle, and the tagged entry is marked finished. Finished entries without a fault leave the buffer from the head, one per cycle and in issue order, and their saved values are dropped. When the head entry carries a fault, the block stops issue and enters rollback. It then walks from the newest entry back to the faulting head and writes one saved value into the register file each cycle. The oldest saved copy of a register is therefore the last one written. At the end it empties the buffer and pulses a done flag with the faulting instruction's PC.

Top module: `hist_rollback_buf`

## Requirements
- R1: While reset is held and right after it is released, iss_ready is 1 and busy, rb_done and rf_we are 0. The first accepted issue gets tag 0.
- R2: An issue is accepted when iss_valid and iss_ready are both 1. iss_tag gives the allocated entry index, which runs 0 to DEPTH-1 and wraps to 0. rf_rd_addr equals iss_dst in the same cycle, and the rf_rd_data seen in that cycle is the old value the entry saves.
- R3: Outside rollback, a completion drives the register file directly in the same cycle: rf_we=cmp_valid, rf_wa=cmp_dst, rf_wd=cmp_data.
- R4: Entries leave from the head strictly in issue order. An entry that finished early stays until every older entry has left. A finished head entry without a fault frees its slot at the second clock edge after its completion.
- R5: With DEPTH (8) entries outstanding, iss_ready is 0.
- R6: A head entry finished with cmp_exc=1 starts rollback. busy is 1 for one cycle per entry from the newest entry down to the head. Each such cycle drives rf_we=1 with that entry's saved register and old value, newest first.
- R7: During rollback iss_ready is 0, and completions presented then do not reach the register file.
- R8: Rollback ends with a one-cycle rb_done pulse whose rb_pc holds the faulting entry's PC. The buffer is then empty, so the next issue gets tag 0.
- R9: A faulted entry that is not at the head does not start rollback until all older entries have left cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_dst | input | RA_W | Destination register of the issuing instruction |
| iss_pc | input | PC_W | PC of the issuing instruction |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_tag | output | PTR_W | Entry index given to the issue |
| rf_rd_addr | output | RA_W | Register file read address (old value) |
| rf_rd_data | input | DATA_W | Register file read data, same cycle |
| cmp_valid | input | 1 | Completion present |
| cmp_tag | input | PTR_W | Entry of the completing instruction |
| cmp_exc | input | 1 | Completing instruction raised an exception |
| cmp_dst | input | RA_W | Destination register of the result |
| cmp_data | input | DATA_W | Result value |
| rf_we | output | 1 | Register file write enable |
| rf_wa | output | RA_W | Register file write address |
| rf_wd | output | DATA_W | Register file write data |
| busy | output | 1 | Rollback in progress |
| rb_done | output | 1 | One-cycle pulse when rollback ends |
| rb_pc | output | PC_W | PC of the faulting instruction |

## Verification
Completion writes are combinational, so the bench reads its register model at the falling edge after the completion's clock edge. A clean head frees its slot one edge later, so iss_ready is sampled two edges after the completion and is also held low before that point. Rollback starts at the second edge after the head's faulting completion. A scoreboard queue holds the expected restore writes, newest first, and a monitor pops and compares one at each falling edge while busy is high. rb_done and rb_pc are checked at the falling edge after the last restore edge, and the final register contents and the next issue tag are checked after that.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic {ST_RUN, ST_ROLL} hb_state_e;

  function automatic int unsigned ptr_next(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic int unsigned ptr_prev(int unsigned p, int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction
endpackage

// File: rtl/hb_entry_ram.sv
module hb_entry_ram #(
  parameter int DEPTH = 8,
  parameter int W     = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/hb_flag_bank.sv
module hb_flag_bank #(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_en,
  input  logic [AW-1:0] alloc_idx,
  input  logic          fin_en,
  input  logic [AW-1:0] fin_idx,
  input  logic          fin_exc,
  input  logic [AW-1:0] head_idx,
  output logic          head_done,
  output logic          head_exc
);
  logic [DEPTH-1:0] done_q;
  logic [DEPTH-1:0] exc_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
      end else if (fin_en && fin_idx == AW'(i)) begin
        done_q[i] <= 1'b1;
        exc_q[i]  <= fin_exc;
      end else if (alloc_en && alloc_idx == AW'(i)) begin
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
      end
    end
  end

  assign head_done = done_q[head_idx];
  assign head_exc  = exc_q[head_idx];
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_valid,
  input  logic            head_done,
  input  logic            head_exc,
  input  logic [PC_W-1:0] walk_pc,
  output logic            iss_ok,
  output logic            iss_fire,
  output logic [AW-1:0]   tail,
  output logic [AW-1:0]   head,
  output logic [AW-1:0]   walk,
  output logic [CW-1:0]   count,
  output logic            rolling,
  output logic            rb_done,
  output logic [PC_W-1:0] rb_pc
);
  hb_state_e state;
  logic      head_fault;
  logic      retire;

  assign head_fault = (count != '0) && head_done && head_exc;
  assign retire     = (count != '0) && head_done && !head_exc;
  assign rolling    = (state == ST_ROLL);
  assign iss_ok     = (state == ST_RUN) && (count != CW'(DEPTH)) && !head_fault;
  assign iss_fire   = iss_valid && iss_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      head    <= '0;
      tail    <= '0;
      walk    <= '0;
      count   <= '0;
      rb_done <= 1'b0;
      rb_pc   <= '0;
    end else begin
      rb_done <= 1'b0;
      if (state == ST_RUN) begin
        if (head_fault) begin
          state <= ST_ROLL;
          walk  <= AW'(ptr_prev(32'(tail), DEPTH));
        end else begin
          if (iss_fire) tail <= AW'(ptr_next(32'(tail), DEPTH));
          if (retire)   head <= AW'(ptr_next(32'(head), DEPTH));
          count <= count + CW'(iss_fire) - CW'(retire);
        end
      end else begin
        if (walk == head) begin
          state   <= ST_RUN;
          head    <= '0;
          tail    <= '0;
          count   <= '0;
          rb_done <= 1'b1;
          rb_pc   <= walk_pc;
        end else begin
          walk <= AW'(ptr_prev(32'(walk), DEPTH));
        end
      end
    end
  end
endmodule

// File: rtl/hist_rollback_buf.sv
module hist_rollback_buf #(
  parameter int DEPTH  = 8,
  parameter int NREG   = 32,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int RA_W  = $clog2(NREG),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ENT_W = RA_W + PC_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [RA_W-1:0]   iss_dst,
  input  logic [PC_W-1:0]   iss_pc,
  output logic              iss_ready,
  output logic [PTR_W-1:0]  iss_tag,
  output logic [RA_W-1:0]   rf_rd_addr,
  input  logic [DATA_W-1:0] rf_rd_data,
  input  logic              cmp_valid,
  input  logic [PTR_W-1:0]  cmp_tag,
  input  logic              cmp_exc,
  input  logic [RA_W-1:0]   cmp_dst,
  input  logic [DATA_W-1:0] cmp_data,
  output logic              rf_we,
  output logic [RA_W-1:0]   rf_wa,
  output logic [DATA_W-1:0] rf_wd,
  output logic              busy,
  output logic              rb_done,
  output logic [PC_W-1:0]   rb_pc
);
  logic [PTR_W-1:0]  tail, head, walk;
  logic [CNT_W-1:0]  count;
  logic              iss_fire, rolling, head_done, head_exc;
  logic [ENT_W-1:0]  ent_rd;
  logic [RA_W-1:0]   ent_dst;
  logic [PC_W-1:0]   ent_pc;
  logic [DATA_W-1:0] ent_old;

  assign rf_rd_addr = iss_dst;
  assign iss_tag    = tail;
  assign busy       = rolling;
  assign {ent_dst, ent_pc, ent_old} = ent_rd;

  hb_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst(rst), .iss_valid(iss_valid),
    .head_done(head_done), .head_exc(head_exc), .walk_pc(ent_pc),
    .iss_ok(iss_ready), .iss_fire(iss_fire),
    .tail(tail), .head(head), .walk(walk), .count(count),
    .rolling(rolling), .rb_done(rb_done), .rb_pc(rb_pc)
  );

  hb_entry_ram #(.DEPTH(DEPTH), .W(ENT_W)) u_ram (
    .clk(clk), .wr_en(iss_fire), .wr_addr(tail),
    .wr_data({iss_dst, iss_pc, rf_rd_data}),
    .rd_addr(walk), .rd_data(ent_rd)
  );

  hb_flag_bank #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst),
    .alloc_en(iss_fire), .alloc_idx(tail),
    .fin_en(cmp_valid && !rolling), .fin_idx(cmp_tag), .fin_exc(cmp_exc),
    .head_idx(head), .head_done(head_done), .head_exc(head_exc)
  );

  always_comb begin
    if (rolling) begin
      rf_we = 1'b1;
      rf_wa = ent_dst;
      rf_wd = ent_old;
    end else begin
      rf_we = cmp_valid;
      rf_wa = cmp_dst;
      rf_wd = cmp_data;
    end
  end
endmodule

// File: rtl/hb_rollback_chk.sv
module hb_rollback_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_ready,
  input logic             rf_we,
  input logic             busy,
  input logic             rb_done,
  input logic [CNT_W-1:0] count
);
  AST_FULL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(DEPTH)) |-> !iss_ready); // R5
  AST_ROLL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (rst)
    busy |-> !iss_ready); // R7
  AST_ROLL_DRIVES_RF: assert property (@(posedge clk) disable iff (rst)
    busy |-> rf_we); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rb_done |=> !rb_done); // R8
  AST_DONE_ENDS_ROLL: assert property (@(posedge clk) disable iff (rst)
    rb_done |-> ($past(busy) && !busy)); // R8
  AST_EMPTY_AFTER_ROLL: assert property (@(posedge clk) disable iff (rst)
    rb_done |-> (count == '0)); // R8
endmodule

bind hist_rollback_buf hb_rollback_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .iss_ready(iss_ready), .rf_we(rf_we),
  .busy(busy), .rb_done(rb_done), .count(count)
);

// File: tb/hist_rollback_buf_test.sv
module hist_rollback_buf_test;
  localparam int DEPTH = 8;
  localparam int NREG = 32;
  localparam int DW = 32;
  localparam int PW = 32;
  localparam int RA = $clog2(NREG);
  localparam int TW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0;
  logic [RA-1:0] iss_dst = '0;
  logic [PW-1:0] iss_pc = '0;
  logic iss_ready;
  logic [TW-1:0] iss_tag;
  logic [RA-1:0] rf_rd_addr;
  logic [DW-1:0] rf_rd_data;
  logic cmp_valid = 1'b0;
  logic [TW-1:0] cmp_tag = '0;
  logic cmp_exc = 1'b0;
  logic [RA-1:0] cmp_dst = '0;
  logic [DW-1:0] cmp_data = '0;
  logic rf_we;
  logic [RA-1:0] rf_wa;
  logic [DW-1:0] rf_wd;
  logic busy, rb_done;
  logic [PW-1:0] rb_pc;

  always #2 clk = ~clk;

  hist_rollback_buf #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DW), .PC_W(PW)) uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_pc(iss_pc),
    .iss_ready(iss_ready), .iss_tag(iss_tag), .rf_rd_addr(rf_rd_addr),
    .rf_rd_data(rf_rd_data), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .cmp_exc(cmp_exc), .cmp_dst(cmp_dst), .cmp_data(cmp_data),
    .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd),
    .busy(busy), .rb_done(rb_done), .rb_pc(rb_pc)
  );

  // environment register file
  logic [DW-1:0] regs [NREG];
  initial for (int i = 0; i < NREG; i++) regs[i] = DW'(i * 16 + 1);
  assign rf_rd_data = regs[rf_rd_addr];
  always @(posedge clk) if (rf_we) regs[rf_wa] <= rf_wd;

  int n_checks = 0;
  int n_fail = 0;
  logic [RA-1:0] h_dst [DEPTH];
  logic [DW-1:0] h_old [DEPTH];
  logic [RA-1:0] exp_wa [$];
  logic [DW-1:0] exp_wd [$];
  int roll_writes = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // driver: issue one instruction, capture its tag and the old value
  task automatic issue(input int dst, input int pc, output int tag);
    @(negedge clk);
    iss_valid = 1'b1; iss_dst = RA'(dst); iss_pc = PW'(pc);
    #0.1;
    tag = int'(iss_tag);
    h_dst[tag] = RA'(dst);
    h_old[tag] = regs[dst];
    @(posedge clk); #1 iss_valid = 1'b0;
  endtask

  task automatic complete(input int tag, input int dst, input int data, input bit exc);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_tag = TW'(tag); cmp_dst = RA'(dst);
    cmp_data = DW'(data); cmp_exc = exc;
    @(posedge clk); #1 cmp_valid = 1'b0; cmp_exc = 1'b0;
  endtask

  // push expected restore writes, newest entry down to head
  task automatic expect_roll(input int newest, input int oldest);
    for (int t = newest; ; t = (t == 0) ? DEPTH - 1 : t - 1) begin
      exp_wa.push_back(h_dst[t]);
      exp_wd.push_back(h_old[t]);
      if (t == oldest) break;
    end
  endtask

  // monitor: compare each restore write against the scoreboard
  always @(negedge clk) begin
    if (!rst && busy) begin
      roll_writes++;
      if (exp_wa.size() == 0) begin
        check(1'b0, "R6", "unexpected restore write addr", rf_wa, 0);
      end else begin
        logic [RA-1:0] ea;
        logic [DW-1:0] ed;
        ea = exp_wa.pop_front();
        ed = exp_wd.pop_front();
        check(rf_we && rf_wa == ea, "R6", "restore write address", rf_wa, ea);
        check(rf_wd == ed, "R2", "restored old value", rf_wd, ed);
      end
    end
  end

  initial begin
    #(4 * 20000);
    check(1'b0, "R8", "watchdog expired", 0, 1);
    finish_run();
  end

  int tg;
  int tags [DEPTH];
  logic [DW-1:0] snap6, snap9;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(iss_ready == 1'b1, "R1", "reset iss_ready", iss_ready, 1);
    check(busy == 1'b0 && rb_done == 1'b0, "R1", "reset busy/done", {busy, rb_done}, 0);
    check(rf_we == 1'b0, "R1", "reset rf_we", rf_we, 0);
    rst = 1'b0;
    @(negedge clk);
    check(iss_tag == '0, "R1", "first tag", iss_tag, 0);

    // fill the buffer
    for (int i = 0; i < DEPTH; i++) begin
      issue(i + 1, 32'h100 + 4 * i, tags[i]);
      check(tags[i] == i, "R2", "tag sequence", tags[i], i);
    end
    @(negedge clk);
    check(iss_ready == 1'b0, "R5", "full blocks issue", iss_ready, 0);

    // out-of-order completion: written at once, but no early release
    complete(3, 4, 32'h333, 1'b0);
    @(negedge clk);
    check(regs[4] == 32'h333, "R3", "direct rf write", regs[4], 32'h333);
    @(negedge clk);
    check(iss_ready == 1'b0, "R4", "younger entry held", iss_ready, 0);

    complete(0, 1, 32'h111, 1'b0);
    @(negedge clk);
    check(iss_ready == 1'b0, "R4", "head not yet freed", iss_ready, 0);
    @(negedge clk);
    check(iss_ready == 1'b1, "R4", "head freed", iss_ready, 1);

    issue(20, 32'h180, tg);
    check(tg == 0, "R2", "tag wraps", tg, 0);
    @(negedge clk);
    check(iss_ready == 1'b0, "R5", "full again", iss_ready, 0);

    complete(1, 2, 32'h222, 1'b0);
    complete(2, 3, 32'h2222, 1'b0);
    repeat (4) @(negedge clk);
    check(iss_ready == 1'b1, "R4", "in-order drain frees slots", iss_ready, 1);
    for (int t = 4; t < DEPTH; t++) complete(t, t + 1, 32'h500 + t, 1'b0);
    complete(0, 20, 32'h520, 1'b0);
    repeat (12) @(negedge clk);
    check(busy == 1'b0, "R4", "clean drain no rollback", busy, 0);

    // exception scenario, head is now entry 1
    snap6 = regs[6]; snap9 = regs[9];
    issue(3, 32'h200, tags[0]);
    issue(6, 32'h204, tags[1]);
    complete(tags[1], 6, 32'hAAAA, 1'b1);
    issue(6, 32'h208, tags[2]);
    issue(9, 32'h20C, tags[3]);
    check(h_old[tags[2]] == 32'hAAAA, "R2", "old value after early write",
          h_old[tags[2]], 32'hAAAA);
    complete(tags[2], 6, 32'hBBBB, 1'b0);
    complete(tags[3], 9, 32'hCCCC, 1'b0);
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R9", "fault behind older entry waits", busy, 0);

    expect_roll(tags[3], tags[1]);
    roll_writes = 0;
    complete(tags[0], 3, 32'hDDDD, 1'b0);
    begin
      int guard = 0;
      while (!busy && guard < 20) begin @(negedge clk); guard++; end
    end
    check(busy == 1'b1, "R6", "rollback started", busy, 1);
    check(iss_ready == 1'b0, "R7", "issue blocked in rollback", iss_ready, 0);
    cmp_valid = 1'b1; cmp_tag = TW'(tags[3]); cmp_dst = 5'd9; cmp_data = 32'hDEAD;
    @(posedge clk); #1 cmp_valid = 1'b0;
    begin
      int guard = 0;
      while (!rb_done && guard < 20) begin @(negedge clk); guard++; end
    end
    check(rb_done == 1'b1, "R8", "done pulse", rb_done, 1);
    check(rb_pc == 32'h204, "R8", "faulting pc", rb_pc, 32'h204);
    check(busy == 1'b0, "R8", "busy ends with done", busy, 0);
    check(roll_writes == 3, "R6", "restore count", roll_writes, 3);
    check(exp_wa.size() == 0, "R6", "scoreboard drained", exp_wa.size(), 0);
    @(negedge clk);
    check(rb_done == 1'b0, "R8", "done is one cycle", rb_done, 0);
    check(regs[3] == 32'hDDDD, "R6", "older result kept", regs[3], 32'hDDDD);
    check(regs[6] == snap6, "R6", "newest-first restore r6", regs[6], snap6);
    check(regs[9] == snap9, "R7", "completion during rollback dropped", regs[9], snap9);
    check(iss_tag == '0 && iss_ready == 1'b1, "R8", "buffer emptied",
          {iss_ready, iss_tag}, 8);

    finish_run();
  end
endmodule